// File: doc/BRIEF.md
# Aligned Transfer Segment Splitter

This block accepts one memory segment at a time, a start address and a byte length, and breaks it into a stream of sub-segment records. Each record fits a 13-bit byte count. When a segment is longer than that limit, it is not cut into maximum-size pieces with a short leftover. Instead, the block works out how many pieces the remaining length needs and cuts the next piece to about an equal share, rounded down to a multiple of four bytes. This keeps every piece that is not the last one word-aligned and avoids a tiny tail.

A producer hands segments over through a valid/ready handshake. A consumer drains `{address, length, last}` records through a second valid/ready handshake. Segments whose start address is not word-aligned, and segments of length zero, are refused: the block pulses a reject flag and emits nothing. The piece sizes come from an iterative restoring divider. The block therefore takes several dozen cycles per long piece and accepts no new segment until the current one is fully handed to the output register.

Top module: `seg_split`

## Requirements
- R1: A segment of length 1 to 8191 bytes is emitted as exactly one record, with the input address, the input length and the last flag set.
- R2: While the remaining length R exceeds 8191, the next record length is floor(R / ceil(R / 8188)) with its two low bits cleared. R is recomputed after every record, and the first R at or below 8191 is emitted whole as the final record.
- R3: Every emitted record has a length between 1 and 8191 inclusive, and every record without the last flag has a length that is a multiple of 4.
- R4: The first record carries the input address, each later record's address equals the previous record's address plus its length, and the record lengths sum to the input length.
- R5: The last flag is 1 on the final record of a segment and 0 on all others.
- R6: A segment whose address has bit 0 or bit 1 set is rejected: reject_o is 1 for exactly the one cycle after the accepting clock edge, no record is emitted, and the input stays ready.
- R7: A segment of length zero is rejected in the same way as R6.
- R8: seg_ready_o is 1 after reset and whenever no segment is being split. It is 0 from the cycle after a valid segment is accepted until the edge at which that segment's final record enters the output register.
- R9: While piece_valid_o is 1 and piece_ready_i is 0, the record on the output stays valid and unchanged on the next cycle.
- R10: After reset, piece_valid_o and reject_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seg_valid_i | input | 1 | Segment offered |
| seg_ready_o | output | 1 | Segment can be taken |
| seg_addr_i | input | ADDR_W (32) | Segment start address |
| seg_len_i | input | LEN_W (24) | Segment length in bytes |
| piece_valid_o | output | 1 | Record present |
| piece_ready_i | input | 1 | Consumer takes the record |
| piece_addr_o | output | ADDR_W (32) | Record start address |
| piece_len_o | output | CNT_W (13) | Record length in bytes |
| piece_last_o | output | 1 | Final record of the segment |
| reject_o | output | 1 | One-cycle pulse for a refused segment |

## Verification
The assertions watch the properties that hold on every cycle:
- record lengths stay within range, and pieces other than the last stay aligned;
- the record is held under backpressure;
- a refused handshake produces a reject pulse;
- an accepted handshake drops the input ready;
- the divider's partial remainder stays below its divisor.

Only the bench scenarios can show the exact piece sizes the equal-share rule yields, the address chain and the sum of the pieces across a segment, and the placement of the last flag. They also cover the single-record boundary at 8191 against 8192, and the block's return to the ready state after a segment ends.

// File: rtl/seg_split_pkg.sv
package seg_split_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PLAN  = 3'd1,
        ST_MULT  = 3'd2,
        ST_CHUNK = 3'd3,
        ST_EMIT  = 3'd4
    } split_state_e;

endpackage

// File: rtl/seg_split_div.sv
module seg_split_div #(
    parameter int W = 25
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         start_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic         done_o,
    output logic [W-1:0] quot_o
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [W-1:0]  rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  dvs;
        logic          busy;
        logic          done;
    } div_t;

    div_t div_d, div_q;
    logic [W:0] trial;

    always_comb begin
        div_d      = div_q;
        div_d.done = 1'b0;
        trial      = {div_q.rem, div_q.quo[W-1]};
        if (start_i && !div_q.busy) begin
            div_d.quo  = dividend_i;
            div_d.rem  = '0;
            div_d.dvs  = divisor_i;
            div_d.cnt  = CW'(W);
            div_d.busy = 1'b1;
        end else if (div_q.busy) begin
            if (trial >= {1'b0, div_q.dvs}) begin
                div_d.rem = W'(trial - {1'b0, div_q.dvs});
                div_d.quo = {div_q.quo[W-2:0], 1'b1};
            end else begin
                div_d.rem = trial[W-1:0];
                div_d.quo = {div_q.quo[W-2:0], 1'b0};
            end
            div_d.cnt = div_q.cnt - 1'b1;
            if (div_q.cnt == CW'(1)) begin
                div_d.busy = 1'b0;
                div_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) div_q <= '0;
        else         div_q <= div_d;
    end

    assign done_o = div_q.done;
    assign quot_o = div_q.quo;

    // R2: restoring step keeps the partial remainder below the divisor
    a_r2_div_rem_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div_q.busy |-> (div_q.rem < div_q.dvs));

    // R2: completion is a single-cycle pulse
    a_r2_div_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div_q.done |=> !div_q.done);

endmodule

// File: rtl/seg_split_out.sv
module seg_split_out #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 13
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  len_i,
    input  logic              last_i,
    output logic              can_load_o,
    output logic              valid_o,
    input  logic              ready_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CNT_W-1:0]  len_o,
    output logic              last_o
);
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  len;
        logic              last;
    } rec_t;

    rec_t rec_d, rec_q;

    assign can_load_o = !rec_q.valid || ready_i;

    always_comb begin
        rec_d = rec_q;
        if (rec_q.valid && ready_i) rec_d.valid = 1'b0;
        if (load_i && can_load_o) begin
            rec_d.valid = 1'b1;
            rec_d.addr  = addr_i;
            rec_d.len   = len_i;
            rec_d.last  = last_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rec_q <= '0;
        else         rec_q <= rec_d;
    end

    assign valid_o = rec_q.valid;
    assign addr_o  = rec_q.addr;
    assign len_o   = rec_q.len;
    assign last_o  = rec_q.last;

    a_r9_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && !ready_i) |=> (valid_o && $stable(addr_o) && $stable(len_o) && $stable(last_o)));

endmodule

// File: rtl/seg_split.sv
module seg_split
    import seg_split_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 24,
    parameter int CNT_W   = 13,
    parameter int ALIGN_W = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              seg_valid_i,
    output logic              seg_ready_o,
    input  logic [ADDR_W-1:0] seg_addr_i,
    input  logic [LEN_W-1:0]  seg_len_i,
    output logic              piece_valid_o,
    input  logic              piece_ready_i,
    output logic [ADDR_W-1:0] piece_addr_o,
    output logic [CNT_W-1:0]  piece_len_o,
    output logic              piece_last_o,
    output logic              reject_o
);
    localparam int MAX_LEN = (1 << CNT_W) - 1;
    localparam int STEP    = (MAX_LEN >> ALIGN_W) << ALIGN_W;
    localparam int DIV_W   = LEN_W + 1;

    typedef struct packed {
        split_state_e      st;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  rem;
        logic [CNT_W-1:0]  chunk;
        logic              last;
        logic              rej;
    } core_t;

    core_t core_d, core_q;

    logic             div_start, div_done;
    logic [DIV_W-1:0] div_a, div_b, div_quot;
    logic             out_load, out_can_load;

    seg_split_div #(.W(DIV_W)) div_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (div_start),
        .dividend_i (div_a),
        .divisor_i  (div_b),
        .done_o     (div_done),
        .quot_o     (div_quot)
    );

    seg_split_out #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) out_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (out_load),
        .addr_i     (core_q.addr),
        .len_i      (core_q.chunk),
        .last_i     (core_q.last),
        .can_load_o (out_can_load),
        .valid_o    (piece_valid_o),
        .ready_i    (piece_ready_i),
        .addr_o     (piece_addr_o),
        .len_o      (piece_len_o),
        .last_o     (piece_last_o)
    );

    assign seg_ready_o = (core_q.st == ST_IDLE);
    assign reject_o    = core_q.rej;

    always_comb begin
        core_d     = core_q;
        core_d.rej = 1'b0;
        div_start  = 1'b0;
        div_a      = '0;
        div_b      = '0;
        out_load   = 1'b0;
        unique case (core_q.st)
            ST_IDLE: begin
                if (seg_valid_i) begin
                    if ((seg_addr_i[ALIGN_W-1:0] != '0) || (seg_len_i == '0)) begin
                        core_d.rej = 1'b1;
                    end else begin
                        core_d.addr = seg_addr_i;
                        core_d.rem  = seg_len_i;
                        core_d.st   = ST_PLAN;
                    end
                end
            end
            ST_PLAN: begin
                if (core_q.rem <= LEN_W'(MAX_LEN)) begin
                    core_d.chunk = core_q.rem[CNT_W-1:0];
                    core_d.last  = 1'b1;
                    core_d.st    = ST_EMIT;
                end else begin
                    div_start = 1'b1;
                    div_a     = {1'b0, core_q.rem} + DIV_W'(STEP - 1);
                    div_b     = DIV_W'(STEP);
                    core_d.st = ST_MULT;
                end
            end
            ST_MULT: begin
                if (div_done) begin
                    div_start = 1'b1;
                    div_a     = {1'b0, core_q.rem};
                    div_b     = div_quot;
                    core_d.st = ST_CHUNK;
                end
            end
            ST_CHUNK: begin
                if (div_done) begin
                    core_d.chunk = {div_quot[CNT_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
                    core_d.last  = 1'b0;
                    core_d.st    = ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (out_can_load) begin
                    out_load    = 1'b1;
                    core_d.addr = core_q.addr + ADDR_W'(core_q.chunk);
                    core_d.rem  = core_q.rem - LEN_W'(core_q.chunk);
                    core_d.st   = core_q.last ? ST_IDLE : ST_PLAN;
                end
            end
            default: core_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) core_q <= '0;
        else         core_q <= core_d;
    end

    a_r3_len_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        piece_valid_o |-> ((piece_len_o != '0) && (int'(piece_len_o) <= MAX_LEN)));

    a_r3_mid_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (piece_valid_o && !piece_last_o) |-> (piece_len_o[ALIGN_W-1:0] == '0));

    // R6 and R7: refused handshake gives a pulse and keeps the input ready
    a_r6_reject_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seg_valid_i && seg_ready_o &&
         ((seg_addr_i[ALIGN_W-1:0] != '0) || (seg_len_i == '0)))
        |=> (reject_o && seg_ready_o));

    a_r8_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seg_valid_i && seg_ready_o &&
         (seg_addr_i[ALIGN_W-1:0] == '0) && (seg_len_i != '0))
        |=> (!seg_ready_o && !reject_o));

endmodule

// File: tb/seg_split_tb.sv
module seg_split_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAXL = 8191;
    localparam int STEPL = 8188;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_valid = 1'b0;
    logic        seg_ready;
    logic [31:0] seg_addr = '0;
    logic [23:0] seg_len = '0;
    logic        piece_valid;
    logic        piece_ready = 1'b0;
    logic [31:0] piece_addr;
    logic [12:0] piece_len;
    logic        piece_last;
    logic        reject;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_split dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .seg_valid_i   (seg_valid),
        .seg_ready_o   (seg_ready),
        .seg_addr_i    (seg_addr),
        .seg_len_i     (seg_len),
        .piece_valid_o (piece_valid),
        .piece_ready_i (piece_ready),
        .piece_addr_o  (piece_addr),
        .piece_len_o   (piece_len),
        .piece_last_o  (piece_last),
        .reject_o      (reject)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int next_piece(input int rem);
        int mult;
        if (rem <= MAXL) return rem;
        mult = (rem + STEPL - 1) / STEPL;
        return (rem / mult) & ~3;
    endfunction

    task automatic send(input logic [31:0] a, input int len);
        @(negedge clk);
        seg_valid = 1'b1;
        seg_addr  = a;
        seg_len   = 24'(len);
        while (!seg_ready) @(negedge clk);
        @(negedge clk);
        seg_valid = 1'b0;
    endtask

    // R1 R2 R4 R5 R8 R9: split one segment and compare every record
    task automatic run_segment(input logic [31:0] a, input int len, input bit bp);
        int rem = len;
        logic [31:0] exp_a = a;
        int guard = 0;
        bit hold = 1'b0;
        logic [31:0] h_addr;
        logic [12:0] h_len;
        logic h_last;
        int exp_len;
        send(a, len);
        check(seg_ready == 1'b0, "R8", "ready after accept", seg_ready, 0);
        while (rem > 0 && guard < 20000) begin
            @(negedge clk);
            guard++;
            if (hold) begin
                check(piece_valid && piece_addr == h_addr && piece_len == h_len &&
                      piece_last == h_last, "R9", "held record changed",
                      piece_len, h_len);
            end
            piece_ready = bp ? ((guard % 3) != 0) : 1'b1;
            hold = 1'b0;
            if (piece_valid) begin
                if (piece_ready) begin
                    exp_len = next_piece(rem);
                    check(piece_addr == exp_a, "R4", "record address", piece_addr, exp_a);
                    check(int'(piece_len) == exp_len, (len <= MAXL) ? "R1" : "R2",
                          "record length", piece_len, exp_len);
                    check(piece_last == (exp_len == rem), "R5", "last flag",
                          piece_last, exp_len == rem);
                    exp_a = exp_a + 32'(exp_len);
                    rem   = rem - exp_len;
                    if (rem == 0)
                        check(seg_ready == 1'b1, "R8", "ready after final record", seg_ready, 1);
                    else
                        check(seg_ready == 1'b0, "R8", "ready mid segment", seg_ready, 0);
                end else begin
                    hold = 1'b1;
                    h_addr = piece_addr;
                    h_len  = piece_len;
                    h_last = piece_last;
                end
            end
        end
        check(rem == 0, "R4", "bytes left unsplit", rem, 0);
        @(negedge clk);
        piece_ready = 1'b0;
    endtask

    task automatic reject_case(input logic [31:0] a, input int len, input string req);
        @(negedge clk);
        seg_valid = 1'b1;
        seg_addr  = a;
        seg_len   = 24'(len);
        while (!seg_ready) @(negedge clk);
        @(negedge clk);
        seg_valid = 1'b0;
        check(reject == 1'b1, req, "reject pulse", reject, 1);
        check(seg_ready == 1'b1, req, "ready after reject", seg_ready, 1);
        @(negedge clk);
        check(reject == 1'b0, req, "reject width", reject, 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(piece_valid == 1'b0, req, "record after reject", piece_valid, 0);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(seg_ready == 1'b1, "R8", "reset ready", seg_ready, 1);
        check(piece_valid == 1'b0, "R10", "reset valid", piece_valid, 0);
        check(reject == 1'b0, "R10", "reset reject", reject, 0);

        run_segment(32'h0000_1000, 100, 1'b0);       // R1
        run_segment(32'h0000_2000, 1, 1'b0);         // R1 smallest
        run_segment(32'h0001_0000, MAXL, 1'b0);      // R1 boundary
        run_segment(32'h0002_0000, MAXL + 1, 1'b0);  // R2 boundary
        run_segment(32'h0003_0004, 20001, 1'b1);     // R2 R9
        run_segment(32'h0010_0000, 100003, 1'b1);    // R2 R3 R9
        reject_case(32'h0000_4002, 64, "R6");
        reject_case(32'h0000_4001, 64, "R6");
        reject_case(32'h0000_4000, 0, "R7");
        run_segment(32'h0000_8000, 16377, 1'b0);     // R2 after rejects

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule